// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. It holds a byte array and an address counter that persists between transfers. SCL and SDA are sampled with a faster system clock. The block finds start and stop conditions, matches a fixed 7-bit device address, and then runs one of two kinds of transfer. A write transfer loads a word address and stores one data byte. A read transfer returns bytes starting at the address counter. The only output is an open-drain enable: when `sda_oe_o` is high, the pad pulls SDA low.

The address counter always points one past the last byte that was read or written. A read with no address phase therefore continues where the previous access stopped. To read from a chosen address, the master first sends a write transfer that carries only the word address. It then issues a repeated start and the device address with the read bit set. During a read, the master's answer in the ninth clock of each byte decides the next step. An acknowledge fetches another byte. A no-acknowledge makes the slave let go of the bus.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` low) and the address counter is 0. Reset does not clear the byte array contents.
- R2: A start is SDA falling while SCL is high, and it is accepted in any state, including the middle of a byte. It restarts reception of the slave address byte. A stop is SDA rising while SCL is high, and it returns the block to idle with SDA released.
- R3: The slave address byte arrives MSB first. Bits 7..1 are compared with DEV_ADDR, and bit 0 selects the direction (1 = read, 0 = write). On a match, the slave pulls SDA low during the ninth clock.
- R4: A byte whose bits 7..1 differ from DEV_ADDR gets no acknowledge. Until the next start, the slave drives nothing and writes nothing, whatever bytes follow.
- R5: In a write transfer, the byte after the slave address is the word address and it loads the counter. The next byte is stored at that address. Both bytes are acknowledged, and the counter then holds the address plus one.
- R6: In a read transfer, the slave sends the byte at the address counter, MSB first, and the counter advances by one.
- R7: A random read is a write transfer that carries only a word address, followed by a repeated start with no stop and the read direction. It returns the byte at that word address and writes nothing.
- R8: If the master pulls SDA low in the ninth clock of a read byte, the slave sends the next byte from the advanced counter. The counter wraps from 2**ADDR_W-1 to 0.
- R9: If the master leaves SDA high in the ninth clock of a read byte, the slave drives no further bits until a start or a stop. The counter has then advanced only by the bytes actually sent.
- R10: `sda_oe_o` changes only while SCL is low. It is high only while the slave is acknowledging or sending a 0 data bit. It stays low in idle and while the slave is ignoring the bus.
- R11: A write transfer stores one data byte only. A further data byte in the same transfer is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: high pulls SDA low |

## Verification
The bench builds the block with DEV_ADDR set to 7'h3A rather than the default. Every acknowledge and every ignored transfer is therefore decided by the parameter, not by a constant in the code. ADDR_W stays at 8, so the full 256-byte array exists and a sequential read can cross from 255 to 0. SYNC_STAGES is raised to 3. This deepens the synchronizer chain and adds a cycle of latency between the pad and the response, which the bench's SCL phases must absorb.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } ee2w_state_t;

endpackage

// File: rtl/ee2w_sync.sv
// Brings SCL/SDA into the clk domain and derives edge and bus condition pulses.
module ee2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // SCL high on both samples; SDA moves
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/ee2w_mem.sv
// Byte array: one write port, one registered read port (block RAM friendly).
module ee2w_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/ee2w_ctrl.sv
// Transfer sequencer: bit counting, address match, acknowledge, address counter.
module ee2w_ctrl
  import ee2w_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_wadr,
  output logic [BYTE_W-1:0] mem_wdat,
  output logic [AW-1:0]     adr_cnt,
  output logic              sda_oe,
  output ee2w_state_t       st_o,
  output logic [3:0]        cnt_o
);

  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);
  localparam logic [3:0] BITS_LAST = 4'(BYTE_W - 1);

  ee2w_state_t       st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              is_read;
  logic              m_ack;
  logic              oe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_read  <= 1'b0;
      m_ack    <= 1'b0;
      adr_cnt  <= '0;
      mem_we   <= 1'b0;
      mem_wadr <= '0;
      mem_wdat <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_ev) begin
        st      <= ST_DEV;
        bit_cnt <= '0;
      end else if (stop_ev) begin
        st      <= ST_IDLE;
        bit_cnt <= '0;
      end else begin
        unique case (st)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise && bit_cnt < BITS_FULL) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == BITS_FULL) begin
              bit_cnt <= '0;
              if (st == ST_DEV) begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  is_read <= rx_sh[0];
                  st      <= ST_DEV_ACK;
                end else begin
                  st <= ST_HOLD;
                end
              end else if (st == ST_WADR) begin
                adr_cnt <= rx_sh[AW-1:0];
                st      <= ST_WADR_ACK;
              end else begin
                mem_we   <= 1'b1;
                mem_wadr <= adr_cnt;
                mem_wdat <= rx_sh;
                adr_cnt  <= adr_cnt + 1'b1;
                st       <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                tx_sh   <= rd_data;
                adr_cnt <= adr_cnt + 1'b1;
                st      <= ST_RDAT;
              end else begin
                st <= ST_WADR;
              end
            end
          end
          ST_WADR_ACK: if (scl_fall) st <= ST_WDAT;
          ST_WDAT_ACK: if (scl_fall) st <= ST_HOLD;
          ST_RDAT: begin
            if (scl_fall) begin
              if (bit_cnt == BITS_LAST) begin
                bit_cnt <= '0;
                st      <= ST_RACK;
              end else begin
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh   <= rd_data;
                adr_cnt <= adr_cnt + 1'b1;
                st      <= ST_RDAT;
              end else begin
                st <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: oe_d = 1'b1;
      ST_RDAT:                              oe_d = ~tx_sh[BYTE_W-1];
      default:                              oe_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sda_oe <= 1'b0;
    else     sda_oe <= oe_d;
  end

  assign st_o  = st;
  assign cnt_o = bit_cnt;

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
  import ee2w_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_ev;
  logic              stop_ev;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wadr;
  logic [BYTE_W-1:0] mem_wdat;
  logic [ADDR_W-1:0] adr_cnt;
  logic [BYTE_W-1:0] rd_data;
  ee2w_state_t       st;
  logic [3:0]        bit_cnt;

  ee2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  ee2w_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .mem_we   (mem_we),
    .mem_wadr (mem_wadr),
    .mem_wdat (mem_wdat),
    .adr_cnt  (adr_cnt),
    .sda_oe   (sda_oe_o),
    .st_o     (st),
    .cnt_o    (bit_cnt)
  );

  ee2w_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wadr),
    .wdata (mem_wdat),
    .raddr (adr_cnt),
    .rdata (rd_data)
  );

endmodule

// File: rtl/ee2w_chk.sv
module ee2w_chk
  import ee2w_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        scl_lvl,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        sda_oe,
  input ee2w_state_t st,
  input logic [3:0]  cnt
);

  // R2: a start always restarts slave address reception from bit zero
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (st == ST_DEV && cnt == 4'd0));

  // R2: a stop releases SDA once the output register has followed
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_ev |-> ##2 !sda_oe);

  // R10: the enable only moves while SCL is low
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_lvl);

  // R10: idle and ignoring states leave SDA released
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_HOLD) |=> !sda_oe);

  // R9: the master's acknowledge slot is never driven by the slave
  a_r9_master_slot_free: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK) |=> !sda_oe);

endmodule

bind eeprom_2w_slave ee2w_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_lvl  (scl_lvl),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe_o),
  .st       (st),
  .cnt      (bit_cnt)
);

// File: tb/eeprom_2w_slave_tb.sv
`timescale 1ns/1ps
module eeprom_2w_slave_tb;

  localparam logic [6:0] DEV = 7'h3A;
  localparam int         Q   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe_o;
  wire  sda_line;
  assign sda_line = m_sda & ~sda_oe_o;

  always #2.5 clk = ~clk;

  eeprom_2w_slave #(.DEV_ADDR(DEV), .ADDR_W(8), .SYNC_STAGES(3)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [256];
  bit         known [256];
  int         cnt_m = 0;
  int         wr_a [64];
  int         n_wr = 0;

  function automatic logic [7:0] exp_byte(input int a);
    return mdl[a & 255];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b;    hold(Q);
    m_scl = 1'b1; hold(Q);
    m_scl = 1'b0; hold(2);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q/2);
    b = sda_line;
    hold(Q/2);
    m_scl = 1'b0; hold(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_raw(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    recv_raw(v);
    send_bit(!give_ack);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R3 write address ack", ack, 1);
    send_byte(8'(a), ack);       check("R5 word address ack", ack, 1);
    send_byte(d, ack);           check("R5 data ack", ack, 1);
    bus_stop();
    mdl[a] = d;
    known[a] = 1'b1;
    cnt_m = (a + 1) & 255;
    if (n_wr < 64) begin wr_a[n_wr] = a; n_wr++; end
  endtask

  task automatic read_run(input string req, input int n);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      if (known[cnt_m]) check(req, v, exp_byte(cnt_m));
      cnt_m = (cnt_m + 1) & 255;
    end
  endtask

  task automatic do_cur_read(input string req, input int n);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R3 read address ack", ack, 1);
    read_run(req, n);
    bus_stop();
  endtask

  task automatic do_rand_read(input string req, input int a, input int n);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R7 dummy write ack", ack, 1);
    send_byte(8'(a), ack);       check("R7 word address ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R7 repeated start ack", ack, 1);
    cnt_m = a & 255;
    read_run(req, n);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    hold(8);
    rst = 1'b0;
    hold(8);
    // R1: released after reset
    check("R1 oe after reset", sda_oe_o, 0);
    check("R1 line after reset", sda_line, 1);

    do_write(8'h00, 8'hA5);
    do_write(8'hFE, 8'h3C);
    do_write(8'hFF, 8'hC3);
    do_write(8'h01, 8'h5A);
    do_write(8'h10, 8'h77);
    do_write(8'h11, 8'hEE);
    do_write(8'h21, 8'h99);

    // R1: reset clears the counter but keeps the array
    rst = 1'b1; hold(6); rst = 1'b0; hold(6);
    cnt_m = 0;
    do_cur_read("R1 counter zero, array kept", 1);
    do_cur_read("R6 current address read", 1);

    // R8: sequential read across the wrap
    do_rand_read("R8 sequential wrap", 8'hFE, 4);

    // R7: random read then counter follows it
    do_rand_read("R7 random read", 8'h10, 1);
    do_cur_read("R7 counter after random read", 1);

    // R4: foreign address, write attempt
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); check("R4 foreign write nack", ack, 0);
    send_byte(8'h10, ack);               check("R4 ignored byte nack", ack, 0);
    send_byte(8'h00, ack);               check("R4 ignored data nack", ack, 0);
    bus_stop();
    do_rand_read("R4 no write on mismatch", 8'h10, 1);
    // R4: foreign address, read attempt drives nothing
    bus_start();
    send_byte({DEV ^ 7'h40, 1'b1}, ack); check("R4 foreign read nack", ack, 0);
    recv_raw(v);                          check("R4 nothing driven", v, 8'hFF);
    bus_stop();

    // R9: master nack then extra clocks
    do_rand_read("R9 byte before nack", 8'h00, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R3 read ack before nack", ack, 1);
    recv_byte(1'b0, v);          check("R9 byte sent before nack", v, exp_byte(cnt_m));
    cnt_m = (cnt_m + 1) & 255;
    recv_raw(v);                 check("R9 released after nack", v, 8'hFF);
    bus_stop();
    hold(Q);
    check("R10 released after stop", sda_oe_o, 0);
    do_cur_read("R9 counter advanced once", 1);

    // R11: second data byte refused
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R11 address ack", ack, 1);
    send_byte(8'h20, ack);       check("R11 word ack", ack, 1);
    send_byte(8'h11, ack);       check("R11 first data ack", ack, 1);
    send_byte(8'h22, ack);       check("R11 second data nack", ack, 0);
    bus_stop();
    mdl[8'h20] = 8'h11; known[8'h20] = 1'b1;
    do_rand_read("R11 second byte not stored", 8'h20, 2);

    // R2: start in the middle of a byte restarts address reception
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); check("R2 ack after restart", ack, 1);
    read_run("R2 data after restart", 1);
    bus_stop();

    // Random writes and reads
    for (int t = 0; t < 14; t++) begin
      int a;
      a = int'($urandom_range(255, 0));
      do_write(a, 8'($urandom()));
    end
    for (int t = 0; t < 14; t++) begin
      int pick;
      pick = wr_a[$urandom_range(n_wr - 1, 0)];
      if ($urandom_range(1, 0) == 0)
        do_rand_read("R7 random read (rand)", pick, 1 + int'($urandom_range(2, 0)));
      else
        do_cur_read("R6 current read (rand)", 1 + int'($urandom_range(1, 0)));
    end

    hold(20);
    check("R10 idle at end", sda_oe_o, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule